// File: doc/BRIEF.md
# Waveform Playback Sequencer

This block sits between a slow controller and a synchronous sample memory that feeds a DAC. In load mode the controller pushes words into the memory over a valid/ready write channel, and each accepted word becomes a single-cycle write strobe with per-lane write enables. In verify mode the controller sends read requests over a valid/ready channel and receives each memory word back on a response channel, so it can compare the word with what it wrote. In playback mode the block reads the memory at one word per clock. The read select stays asserted for the whole run. The returned words are registered onto a sample output for the DAC.

The playback address comes from a split counter. A narrow low stage advances on every clock. A registered lookahead flag marks the cycle in which the low stage is at its top value, and that flag enables the wide upper stage. The upper stage's enable is therefore a single flop rather than a wide AND of the low bits. Playback always starts at address 0 and runs up to a programmable last address. At that point it either wraps to 0 or stops, depending on a loop bit.

Back-pressure rules: the write channel is ready only in load mode, and never in the cycle in which a strobe is on the memory pins. The request channel is ready only in verify mode with no request outstanding. A response stays valid and stable until the controller takes it. The sample output carries valid only and has no ready, because the memory is read at a fixed rate during playback.

Top module: `wavplay_seq`

## Requirements
- R1: After reset, playing, mem_wr_sel, mem_rd_sel, smp_valid, wr_ready, rq_ready and rsp_valid are all 0.
- R2: ctl_mode value 01 selects load mode. In load mode wr_ready is 1 except in the cycle right after a handshake. A handshake at clock edge k drives mem_wr_sel high, with mem_addr and mem_wdata equal to wr_addr and wr_data, during exactly the cycle after edge k. mem_wr_sel is low again after edge k+1.
- R3: wr_lanes bit 0 enables memory bits [8:0] and bit 1 enables bits [17:9]. mem_lane_we carries these bits only while mem_wr_sel is high and is 0 otherwise. A lane whose bit is 0 keeps its stored value.
- R4: ctl_mode value 10 selects verify mode. A request handshake at edge k drives mem_rd_sel and mem_addr during the cycle after edge k. rsp_valid rises after edge k+2 with the memory word. The response stays valid and stable until rsp_ready is 1, and rq_ready stays 0 until that response is taken.
- R5: A play_start pulse seen while idle (ctl_mode 00 registered, no host operation pending) sets playing after that edge. It puts address 0 on mem_addr and holds mem_rd_sel at 1 for every playing cycle.
- R6: While playing, mem_addr increases by exactly 1 every clock, including across every carry from the low counter stage into the upper stage.
- R7: The word read at the address shown in playing cycle N appears on smp_data with smp_valid 1 after two more clock edges.
- R8: With loop_en 1, the cycle after mem_addr equals last_addr shows address 0, and playback continues.
- R9: With loop_en 0, playing falls in the cycle after mem_addr equals last_addr, and exactly last_addr+1 samples are output.
- R10: A play_stop pulse clears playing at the next edge.
- R11: While playing, a ctl_mode change to load or verify is ignored: wr_ready and rq_ready stay 0, mem_wr_sel stays 0, and memory content is unchanged.
- R12: A play_start pulse in load mode is ignored: playing stays 0 and wr_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_mode | input | 2 | 00 idle, 01 load, 10 verify, 11 idle |
| play_start | input | 1 | Start playback pulse |
| play_stop | input | 1 | Stop playback pulse |
| loop_en | input | 1 | Wrap at last address when 1 |
| last_addr | input | 17 | Final playback address |
| playing | output | 1 | Playback in progress |
| wr_valid | input | 1 | Load word offered |
| wr_ready | output | 1 | Load word accepted |
| wr_addr | input | 17 | Load address |
| wr_data | input | 18 | Load data |
| wr_lanes | input | 2 | Lane enables for the load |
| rq_valid | input | 1 | Verify read request offered |
| rq_ready | output | 1 | Verify request accepted |
| rq_addr | input | 17 | Verify address |
| rsp_valid | output | 1 | Verify word available |
| rsp_ready | input | 1 | Controller takes verify word |
| rsp_data | output | 18 | Verify word |
| smp_valid | output | 1 | Sample valid toward DAC |
| smp_data | output | 18 | Sample toward DAC |
| mem_addr | output | 17 | Memory address |
| mem_rd_sel | output | 1 | Memory read select |
| mem_wr_sel | output | 1 | Memory write strobe |
| mem_lane_we | output | 2 | Memory lane write enables |
| mem_wdata | output | 18 | Memory write data |
| mem_rdata | input | 18 | Memory read data, one cycle after the read edge |

## Verification
The write strobe is due one edge after the write handshake and must be gone one edge later. A verify response is due two edges after its request handshake. A playback address is due one edge after the start or the previous address, and each sample two edges after its address. The bench drives and samples only on falling edges. Each scenario task keeps a small history of the addresses it expected, so it can compare every sample against the word two cycles back. A plain reference counter runs beside the design's address output on every playing cycle.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [1:0] {
    WM_IDLE  = 2'b00,
    WM_LOAD  = 2'b01,
    WM_CHECK = 2'b10,
    WM_PLAY  = 2'b11
  } wmode_e;
endpackage

// File: rtl/wps_addr_counter.sv
module wps_addr_counter #(
  parameter int ADDR_W = 17,
  parameter int LO_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - LO_W;
  localparam logic [LO_W-1:0] LO_TOP = '1;
  localparam logic [LO_W-1:0] LO_PRE = LO_TOP - 1'b1;

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            tc_q;  // lo_q currently holds LO_TOP

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      lo_q <= '0;
      tc_q <= 1'b0;
    end else if (adv) begin
      lo_q <= lo_q + 1'b1;
      tc_q <= (lo_q == LO_PRE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hi_q <= '0;
    end else if (adv && tc_q) begin
      hi_q <= hi_q + 1'b1;
    end
  end

  assign addr = {hi_q, lo_q};

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (addr == $past(addr) + 1'b1));

  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (addr == '0));
endmodule

// File: rtl/wps_host_port.sv
module wps_host_port #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_load,
  input  logic              in_check,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic              rq_valid,
  output logic              rq_ready,
  input  logic [ADDR_W-1:0] rq_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_wdata,
  output logic [LANES-1:0]  op_lanes,
  output logic              wr_strobe,
  output logic              rd_strobe,
  output logic              host_idle
);
  logic wr_fire, rq_fire, rsp_fire;
  logic cap_q, busy_q;

  assign wr_ready  = in_load && !wr_strobe;
  assign rq_ready  = in_check && !busy_q;
  assign wr_fire   = wr_valid && wr_ready;
  assign rq_fire   = rq_valid && rq_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign host_idle = !wr_strobe && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_strobe <= 1'b0;
      rd_strobe <= 1'b0;
      op_addr   <= '0;
      op_wdata  <= '0;
      op_lanes  <= '0;
    end else begin
      wr_strobe <= wr_fire;
      rd_strobe <= rq_fire;
      op_lanes  <= wr_fire ? wr_lanes : '0;
      if (wr_fire) begin
        op_addr  <= wr_addr;
        op_wdata <= wr_data;
      end else if (rq_fire) begin
        op_addr <= rq_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q     <= 1'b0;
      busy_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      cap_q <= rd_strobe;
      if (rq_fire) busy_q <= 1'b1;
      else if (rsp_fire) busy_q <= 1'b0;
      if (cap_q) begin
        rsp_valid <= 1'b1;
        rsp_data  <= mem_rdata;
      end else if (rsp_fire) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  // R3
  lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |-> (op_lanes == '0));

  // R4
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/wps_play_ctl.sv
module wps_play_ctl
  import wps_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_req,
  input  logic              play_start,
  input  logic              play_stop,
  input  logic              loop_en,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              host_idle,
  output logic              playing,
  output logic              in_load,
  output logic              in_check,
  output logic              cnt_clr,
  output logic              cnt_adv
);
  wmode_e mode_q, mode_d, req_mode;
  logic   at_last, start_ok, wrap;

  always_comb begin
    case (mode_req)
      2'b01:   req_mode = WM_LOAD;
      2'b10:   req_mode = WM_CHECK;
      default: req_mode = WM_IDLE;
    endcase
  end

  assign at_last  = (cur_addr == last_addr);
  assign start_ok = play_start && (mode_q == WM_IDLE) && host_idle;
  assign wrap     = playing && at_last && loop_en && !play_stop;

  always_comb begin
    mode_d = mode_q;
    if (mode_q == WM_PLAY) begin
      if (play_stop || (at_last && !loop_en)) mode_d = WM_IDLE;
    end else if (start_ok) begin
      mode_d = WM_PLAY;
    end else begin
      mode_d = req_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= WM_IDLE;
    else        mode_q <= mode_d;
  end

  assign playing  = (mode_q == WM_PLAY);
  assign in_load  = (mode_q == WM_LOAD);
  assign in_check = (mode_q == WM_CHECK);
  assign cnt_clr  = start_ok || wrap;
  assign cnt_adv  = playing;

  // R11
  play_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    playing |=> (mode_q == WM_PLAY || mode_q == WM_IDLE));

  // R12
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == WM_LOAD) |=> (mode_q != WM_PLAY));
endmodule

// File: rtl/wps_sample_out.sv
module wps_sample_out #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              playing,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data
);
  logic tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q     <= 1'b0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else begin
      tag_q     <= playing;
      smp_valid <= tag_q;
      if (tag_q) smp_data <= mem_rdata;
    end
  end

  // R7
  smp_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(playing, 2));
endmodule

// File: rtl/wavplay_seq.sv
module wavplay_seq #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 18,
  parameter int LANES  = 2,
  parameter int LO_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctl_mode,
  input  logic              play_start,
  input  logic              play_stop,
  input  logic              loop_en,
  input  logic [ADDR_W-1:0] last_addr,
  output logic              playing,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic              rq_valid,
  output logic              rq_ready,
  input  logic [ADDR_W-1:0] rq_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_sel,
  output logic              mem_wr_sel,
  output logic [LANES-1:0]  mem_lane_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              in_load, in_check, host_idle;
  logic              cnt_clr, cnt_adv, rd_strobe;
  logic [ADDR_W-1:0] cnt_addr, op_addr;

  wps_play_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .mode_req(ctl_mode),
    .play_start(play_start), .play_stop(play_stop), .loop_en(loop_en),
    .last_addr(last_addr), .cur_addr(cnt_addr), .host_idle(host_idle),
    .playing(playing), .in_load(in_load), .in_check(in_check),
    .cnt_clr(cnt_clr), .cnt_adv(cnt_adv)
  );

  wps_addr_counter #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(cnt_adv), .addr(cnt_addr)
  );

  wps_host_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_host (
    .clk(clk), .rst_n(rst_n), .in_load(in_load), .in_check(in_check),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_lanes(wr_lanes),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_rdata(mem_rdata), .op_addr(op_addr), .op_wdata(mem_wdata),
    .op_lanes(mem_lane_we), .wr_strobe(mem_wr_sel), .rd_strobe(rd_strobe),
    .host_idle(host_idle)
  );

  wps_sample_out #(.DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .playing(playing), .mem_rdata(mem_rdata),
    .smp_valid(smp_valid), .smp_data(smp_data)
  );

  assign mem_addr   = playing ? cnt_addr : op_addr;
  assign mem_rd_sel = playing || rd_strobe;

  // R11
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_sel && mem_rd_sel));
endmodule

// File: tb/test_wavplay_seq.sv
module test_wavplay_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ctl_mode = 2'b00;
  logic        play_start = 1'b0, play_stop = 1'b0, loop_en = 1'b0;
  logic [16:0] last_addr = '0;
  logic        playing;
  logic        wr_valid = 1'b0, wr_ready;
  logic [16:0] wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic [1:0]  wr_lanes = 2'b00;
  logic        rq_valid = 1'b0, rq_ready;
  logic [16:0] rq_addr = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [17:0] rsp_data, smp_data, mem_wdata;
  logic        smp_valid, mem_rd_sel, mem_wr_sel;
  logic [16:0] mem_addr;
  logic [1:0]  mem_lane_we;
  logic [17:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wavplay_seq i_wavplay_seq (
    .clk(clk), .rst_n(rst_n), .ctl_mode(ctl_mode), .play_start(play_start),
    .play_stop(play_stop), .loop_en(loop_en), .last_addr(last_addr),
    .playing(playing), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_lanes(wr_lanes),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .smp_valid(smp_valid), .smp_data(smp_data), .mem_addr(mem_addr),
    .mem_rd_sel(mem_rd_sel), .mem_wr_sel(mem_wr_sel),
    .mem_lane_we(mem_lane_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [17:0] pat(input logic [16:0] a);
    return 18'(a * 37 + 5) ^ 18'h2C3C3;
  endfunction

  // Memory model: 4096 words, indexed by the low address bits
  logic [17:0] mem_m [0:4095];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4096; k++) mem_m[k] <= pat(17'(k));
    end else begin
      if (mem_wr_sel) begin
        if (mem_lane_we[0]) mem_m[mem_addr[11:0]][8:0]  <= mem_wdata[8:0];
        if (mem_lane_we[1]) mem_m[mem_addr[11:0]][17:9] <= mem_wdata[17:9];
      end
      if (mem_rd_sel) mem_rdata <= mem_m[mem_addr[11:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(playing == 0 && mem_wr_sel == 0 && mem_rd_sel == 0, "R1 play/strobes",
        {playing, mem_wr_sel, mem_rd_sel}, 0);
    chk(smp_valid == 0 && wr_ready == 0 && rq_ready == 0 && rsp_valid == 0,
        "R1 handshakes", {smp_valid, wr_ready, rq_ready, rsp_valid}, 0);
  endtask

  task automatic t_load(input logic [16:0] a, input logic [17:0] d,
                        input logic [1:0] ln);
    ctl_mode = 2'b01;
    @(negedge clk);
    chk(wr_ready == 1, "R2 ready in load", wr_ready, 1);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_lanes = ln;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(mem_wr_sel == 1 && mem_addr == a && mem_wdata == d, "R2 strobe",
        {mem_wr_sel, 1'b0, mem_addr}, {1'b1, 1'b0, a});
    chk(wr_ready == 0, "R2 ready low during strobe", wr_ready, 0);
    chk(mem_lane_we == ln, "R3 lane enables", mem_lane_we, ln);
    @(negedge clk);
    chk(mem_wr_sel == 0 && mem_lane_we == 0, "R2 single cycle strobe",
        {mem_wr_sel, mem_lane_we}, 0);
    ctl_mode = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_verify(input logic [16:0] a, input logic [17:0] exp, input string req);
    ctl_mode = 2'b10;
    @(negedge clk);
    chk(rq_ready == 1, "R4 ready in verify", rq_ready, 1);
    rq_valid = 1'b1; rq_addr = a;
    @(negedge clk);
    rq_valid = 1'b0;
    chk(mem_rd_sel == 1 && mem_addr == a, "R4 read cycle", mem_addr, a);
    chk(rq_ready == 0, "R4 busy", rq_ready, 0);
    @(negedge clk);
    chk(rsp_valid == 0, "R4 response not early", rsp_valid, 0);
    @(negedge clk);
    chk(rsp_valid == 1 && rsp_data == exp, req, rsp_data, exp);
    @(negedge clk);
    chk(rsp_valid == 1 && rsp_data == exp, "R4 response held", rsp_data, exp);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 0 && rq_ready == 1, "R4 released", {rsp_valid, rq_ready}, 1);
    ctl_mode = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_lanes();
    logic [17:0] ref_w;
    t_load(17'd3000, 18'h2AB55, 2'b11);
    ref_w = 18'h2AB55;
    t_verify(17'd3000, ref_w, "R4 readback full word");
    t_load(17'd3000, 18'h00000, 2'b01);
    ref_w[8:0] = 9'h000;
    t_verify(17'd3000, ref_w, "R3 low lane only");
    t_load(17'd3000, 18'h3FFFF, 2'b10);
    ref_w[17:9] = 9'h1FF;
    t_verify(17'd3000, ref_w, "R3 high lane only");
    t_load(17'd3001, 18'h15A5A, 2'b00);
    t_verify(17'd3001, pat(17'd3001), "R3 no lanes keeps word");
  endtask

  task automatic t_play(input logic [16:0] last, input bit lp, input int cycles,
                        input int stop_at, input int poke_at, input string tag,
                        output int nsmp);
    logic [16:0] ref_a = '0;
    bit          exp_play = 1'b1;
    logic [17:0] h_addr [0:3];
    bit          h_play [0:3];
    nsmp = 0;
    ctl_mode = 2'b00;
    repeat (2) @(negedge clk);
    last_addr = last; loop_en = lp; play_start = 1'b1;
    @(negedge clk);
    play_start = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      play_stop = 1'b0;
      chk(playing == exp_play, {tag, " playing"}, playing, exp_play);
      if (exp_play) begin
        chk(mem_addr == ref_a, "R6 address vs reference counter", mem_addr, ref_a);
        chk(mem_rd_sel == 1, "R5 read select held", mem_rd_sel, 1);
        chk(wr_ready == 0 && rq_ready == 0 && mem_wr_sel == 0,
            "R11 host side blocked", {wr_ready, rq_ready, mem_wr_sel}, 0);
      end
      h_addr[i % 4] = {1'b0, ref_a};
      h_play[i % 4] = exp_play;
      if (smp_valid) nsmp++;
      if (i >= 2) begin
        chk(smp_valid == h_play[(i - 2) % 4], "R7 sample valid timing",
            smp_valid, h_play[(i - 2) % 4]);
        if (h_play[(i - 2) % 4])
          chk(smp_data == pat(h_addr[(i - 2) % 4][16:0]), "R7 sample data",
              smp_data, pat(h_addr[(i - 2) % 4][16:0]));
      end
      if (i == poke_at) begin
        ctl_mode = 2'b01; wr_valid = 1'b1; wr_addr = 17'd3500;
        wr_data = 18'h0F0F0; wr_lanes = 2'b11;
      end
      if (i == poke_at + 3) begin
        ctl_mode = 2'b00; wr_valid = 1'b0;
      end
      if (exp_play) begin
        if (i == stop_at) begin
          play_stop = 1'b1;
          exp_play = 1'b0;
        end else if (ref_a == last) begin
          if (lp) ref_a = '0;
          else exp_play = 1'b0;
        end else begin
          ref_a = ref_a + 1'b1;
        end
      end
      @(negedge clk);
    end
    play_stop = 1'b0;
  endtask

  task automatic t_start_in_load();
    ctl_mode = 2'b01;
    @(negedge clk);
    play_start = 1'b1;
    @(negedge clk);
    play_start = 1'b0;
    @(negedge clk);
    chk(playing == 0, "R12 start ignored in load", playing, 0);
    chk(wr_ready == 1, "R12 load mode kept", wr_ready, 1);
    ctl_mode = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    #1_200_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_report();
  end

  initial begin
    int n;
    t_reset();
    t_lanes();
    // R9: stop at end, last+1 samples
    t_play(17'd20, 1'b0, 28, -1, -1, "R9", n);
    chk(n == 21, "R9 sample count", n, 21);
    // R8 wrap, R11 mode poke, R10 stop
    t_play(17'd37, 1'b1, 130, 120, 60, "R8 R10", n);
    t_verify(17'd3500, pat(17'd3500), "R11 memory untouched while playing");
    // R6 long run across many low-stage carries
    t_play(17'd1000, 1'b0, 1006, -1, -1, "R6", n);
    chk(n == 1001, "R9 long sample count", n, 1001);
    t_start_in_load();
    finish_report();
  end
endmodule